// File: doc/BRIEF.md
# Continuous-Phase Binary FSK Tone Synthesiser

This block produces the transmit audio for a 300-baud two-tone modem. On every PWM-period tick it advances a 16-bit phase accumulator by one of four increments, chosen by the channel (answer or originate) and by the current data bit (mark or space). It looks up the top six phase bits in a 64-point sine table and registers the result as an 8-bit duty value for a PWM output stage. The tone changes by switching the increment and never by reloading the phase, so the waveform has no phase jump at bit boundaries.

A second 16-bit accumulator, also advanced once per PWM tick, sets the baud timing. Its carry-out gives a one-cycle baud pulse at roughly 300 Hz when the PWM rate is about 31.37 kHz. A built-in twelve-bit repeating test sequence steps once per baud pulse. When it is selected, it replaces the external data bit, so the block can drive a loop-back test with no other source.

Top module: `fsk_tone_gen`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the sample output is 128, the baud pulse is 0, both accumulators hold 0, the test sequence is at its first position and its current bit is 1 (mark).
- R2: The sample for phase p is round(128 + 127*sin(2*pi*k/64)) with k = p[15:10]. The output is 128 at k=0, 255 at k=16 and 1 at k=48.
- R3: On each cycle with pwm_tick_i high, the phase advances modulo 65536 by a step picked from data bit d (1 = mark) and answer_i. When answer_i is 1 the step is 4648 for mark and 4230 for space. When answer_i is 0 the step is 2653 for mark and 2235 for space. The phase is never cleared outside reset.
- R4: The sample output is registered. It changes only at a clock edge where pwm_tick_i is high, and it takes the table value of the phase from before that edge's increment. In cycles with no tick it holds its value.
- R5: Each tick adds 627 to the baud accumulator modulo 65536. If the new value is less than 627, baud_tick_o is high for exactly the next cycle. Otherwise it is low.
- R6: With pattern_sel_i = 1, d is the test-sequence bit and tx_bit_i has no effect. On each baud pulse the sequence moves to its next value, cycling through 1,0,1,1,0,0,1,1,1,0,0,0. The first value takes effect from the pulse onward, and before the first pulse d is 1.
- R7: With pattern_sel_i = 0, d is tx_bit_i as sampled at the tick edge. The test sequence keeps stepping on every baud pulse whichever source is selected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| pwm_tick_i | input | 1 | One-cycle strobe at the PWM period rate |
| tx_bit_i | input | 1 | External transmit data, 1 = mark |
| answer_i | input | 1 | Channel select: 1 = answer (high tones), 0 = originate (low tones) |
| pattern_sel_i | input | 1 | 1 = use the built-in test sequence as data |
| sample_o | output | 8 | Registered sine sample for the PWM duty register |
| baud_tick_o | output | 1 | One-cycle pulse on each baud accumulator wrap |

## Verification
The hardest case to reach is a tick where the baud accumulator wraps, the test sequence steps and the tone step changes, all at once. A wrap happens only about once every 105 ticks, so the bench runs long streams of ticks in test-sequence mode on both channels until the sequence has gone round more than once. Every sample is compared with a phase and baud model that uses the data bit from before the step. Mark and space steps in both channels move the table index through all 64 positions, and the bench records which indices it has seen. Meanwhile tx_bit_i is toggled pseudo-randomly, which shows that it has no effect while the sequence drives the data.

// File: rtl/fsk_tone_pkg.sv
package fsk_tone_pkg;

   typedef enum logic {
      CH_ORIGINATE = 1'b0,
      CH_ANSWER    = 1'b1
   } channel_e;

   // First quarter of a 64-point sine centred on 128, amplitude 127.
   function automatic logic [7:0] quarter_sine(input logic [4:0] k);
      logic [7:0] v;
      case (k)
         5'd0:    v = 8'd128;
         5'd1:    v = 8'd140;
         5'd2:    v = 8'd153;
         5'd3:    v = 8'd165;
         5'd4:    v = 8'd177;
         5'd5:    v = 8'd188;
         5'd6:    v = 8'd199;
         5'd7:    v = 8'd209;
         5'd8:    v = 8'd218;
         5'd9:    v = 8'd226;
         5'd10:   v = 8'd234;
         5'd11:   v = 8'd240;
         5'd12:   v = 8'd245;
         5'd13:   v = 8'd250;
         5'd14:   v = 8'd253;
         5'd15:   v = 8'd254;
         default: v = 8'd255;
      endcase
      return v;
   endfunction

endpackage

// File: rtl/fsk_step_acc.sv
// Modular accumulator with a wrap flag for the step being taken.
module fsk_step_acc #(
   parameter int W             = 16,
   parameter bit WRAP_BY_COMPARE = 1'b1
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         en_i,
   input  logic [W-1:0] step_i,
   output logic [W-1:0] acc_o,
   output logic         wrap_o
);

   logic [W-1:0] acc_q;
   logic [W:0]   sum_w;

   assign sum_w = {1'b0, acc_q} + {1'b0, step_i};

   generate
      if (WRAP_BY_COMPARE) begin : g_cmp
         assign wrap_o = (sum_w[W-1:0] < step_i);
      end else begin : g_carry
         assign wrap_o = sum_w[W];
      end
   endgenerate

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         acc_q <= '0;
      end else if (en_i) begin
         acc_q <= sum_w[W-1:0];
      end
   end

   assign acc_o = acc_q;

endmodule

// File: rtl/fsk_sine_rom.sv
// 64-point sine built from a folded quarter-wave table.
module fsk_sine_rom #(
   parameter int IDX_W = 6,
   parameter int OUT_W = 8
) (
   input  logic [IDX_W-1:0] idx_i,
   output logic [OUT_W-1:0] val_o
);
   import fsk_tone_pkg::*;

   localparam int HALF = 2 ** (IDX_W - 1);
   localparam int QTR  = 2 ** (IDX_W - 2);

   generate
      if (IDX_W != 6 || OUT_W != 8) begin : g_bad_cfg
         $error("fsk_sine_rom: table is defined for 64 points of 8 bits");
      end
   endgenerate

   logic [IDX_W-2:0] fold_w;
   logic [IDX_W-2:0] qidx_w;
   logic [7:0]       mag_w;
   logic [8:0]       neg_w;

   always_comb begin
      fold_w = idx_i[IDX_W-2:0];
      if (int'(fold_w) <= QTR) begin
         qidx_w = fold_w;
      end else begin
         qidx_w = (IDX_W-1)'(HALF - int'(fold_w));
      end
      mag_w = quarter_sine(qidx_w[4:0]);
      neg_w = 9'd256 - {1'b0, mag_w};
      if (idx_i[IDX_W-1]) begin
         val_o = neg_w[7:0];
      end else begin
         val_o = mag_w;
      end
   end

endmodule

// File: rtl/fsk_test_seq.sv
// Repeating test bit sequence stepped by the baud pulse.
module fsk_test_seq #(
   parameter int               LEN  = 12,
   parameter logic [LEN-1:0]   BITS = 12'h1CD,
   localparam int              IW   = (LEN > 1) ? $clog2(LEN) : 1
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          step_i,
   output logic          bit_o,
   output logic [IW-1:0] idx_o
);

   generate
      if (LEN < 2) begin : g_bad_len
         $error("fsk_test_seq: LEN must be at least 2");
      end
   endgenerate

   logic [IW-1:0] idx_q;
   logic          bit_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         idx_q <= '0;
         bit_q <= 1'b1;
      end else if (step_i) begin
         bit_q <= BITS[idx_q];
         if (int'(idx_q) == LEN - 1) begin
            idx_q <= '0;
         end else begin
            idx_q <= idx_q + 1'b1;
         end
      end
   end

   assign bit_o = bit_q;
   assign idx_o = idx_q;

endmodule

// File: rtl/fsk_tone_gen.sv
module fsk_tone_gen #(
   parameter int             PHASE_W   = 16,
   parameter int             IDX_W     = 6,
   parameter int             SAMPLE_W  = 8,
   parameter int             BAUD_W    = 16,
   parameter int             BAUD_STEP = 627,
   parameter int             ANS_SPACE = 4230,
   parameter int             ANS_MARK  = 4648,
   parameter int             ORG_SPACE = 2235,
   parameter int             ORG_MARK  = 2653,
   parameter int             SEQ_LEN   = 12,
   parameter logic [11:0]    SEQ_BITS  = 12'h1CD
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                pwm_tick_i,
   input  logic                tx_bit_i,
   input  logic                answer_i,
   input  logic                pattern_sel_i,
   output logic [SAMPLE_W-1:0] sample_o,
   output logic                baud_tick_o
);
   import fsk_tone_pkg::*;

   localparam int SEQ_IW = $clog2(SEQ_LEN);
   localparam logic [SAMPLE_W-1:0] MID = SAMPLE_W'(2 ** (SAMPLE_W - 1));

   generate
      if (IDX_W > PHASE_W) begin : g_bad_idx
         $error("fsk_tone_gen: IDX_W exceeds PHASE_W");
      end
      if (BAUD_STEP <= 0 || BAUD_STEP >= 2 ** BAUD_W) begin : g_bad_baud
         $error("fsk_tone_gen: BAUD_STEP out of range");
      end
   endgenerate

   logic [PHASE_W-1:0]  step_w;
   logic [PHASE_W-1:0]  phase_q;
   logic                phase_wrap_w;
   logic [BAUD_W-1:0]   baud_q;
   logic                baud_wrap_w;
   logic                baud_step_w;
   logic                seq_bit_w;
   logic [SEQ_IW-1:0]   seq_idx_w;
   logic                data_w;
   logic [SAMPLE_W-1:0] rom_w;
   logic [SAMPLE_W-1:0] sample_q;
   logic                baud_tick_q;
   channel_e            chan_w;

   assign chan_w = answer_i ? CH_ANSWER : CH_ORIGINATE;
   assign data_w = pattern_sel_i ? seq_bit_w : tx_bit_i;

   always_comb begin
      unique case ({chan_w, data_w})
         {CH_ANSWER, 1'b1}:    step_w = PHASE_W'(ANS_MARK);
         {CH_ANSWER, 1'b0}:    step_w = PHASE_W'(ANS_SPACE);
         {CH_ORIGINATE, 1'b1}: step_w = PHASE_W'(ORG_MARK);
         default:              step_w = PHASE_W'(ORG_SPACE);
      endcase
   end

   fsk_step_acc #(.W(PHASE_W), .WRAP_BY_COMPARE(1'b0)) phase_acc_i (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (pwm_tick_i),
      .step_i (step_w),
      .acc_o  (phase_q),
      .wrap_o (phase_wrap_w)
   );

   fsk_step_acc #(.W(BAUD_W), .WRAP_BY_COMPARE(1'b1)) baud_acc_i (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (pwm_tick_i),
      .step_i (BAUD_W'(BAUD_STEP)),
      .acc_o  (baud_q),
      .wrap_o (baud_wrap_w)
   );

   assign baud_step_w = pwm_tick_i & baud_wrap_w;

   fsk_test_seq #(.LEN(SEQ_LEN), .BITS(SEQ_BITS[SEQ_LEN-1:0])) seq_i (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .step_i (baud_step_w),
      .bit_o  (seq_bit_w),
      .idx_o  (seq_idx_w)
   );

   fsk_sine_rom #(.IDX_W(IDX_W), .OUT_W(SAMPLE_W)) rom_i (
      .idx_i (phase_q[PHASE_W-1 -: IDX_W]),
      .val_o (rom_w)
   );

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         sample_q    <= MID;
         baud_tick_q <= 1'b0;
      end else begin
         if (pwm_tick_i) begin
            sample_q <= rom_w;
         end
         baud_tick_q <= baud_step_w;
      end
   end

   assign sample_o    = sample_q;
   assign baud_tick_o = baud_tick_q;

   logic unused_w;
   assign unused_w = phase_wrap_w ^ (|baud_q);

endmodule

// File: rtl/fsk_tone_gen_chk.sv
module fsk_tone_gen_chk #(
   parameter int PHASE_W   = 16,
   parameter int SAMPLE_W  = 8,
   parameter int SEQ_IW    = 4,
   parameter int SEQ_LEN   = 12,
   parameter int ANS_SPACE = 4230,
   parameter int ANS_MARK  = 4648,
   parameter int ORG_SPACE = 2235,
   parameter int ORG_MARK  = 2653
) (
   input logic                clk_i,
   input logic                rst_ni,
   input logic                pwm_tick_i,
   input logic                answer_i,
   input logic [SAMPLE_W-1:0] sample_o,
   input logic                baud_tick_o,
   input logic [PHASE_W-1:0]  phase_q,
   input logic [SEQ_IW-1:0]   seq_idx_w
);
   localparam logic [PHASE_W-1:0] A_S = PHASE_W'(ANS_SPACE);
   localparam logic [PHASE_W-1:0] A_M = PHASE_W'(ANS_MARK);
   localparam logic [PHASE_W-1:0] O_S = PHASE_W'(ORG_SPACE);
   localparam logic [PHASE_W-1:0] O_M = PHASE_W'(ORG_MARK);

   p_pulse_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      baud_tick_o |=> !baud_tick_o);

   p_pulse_after_tick_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      baud_tick_o |-> $past(pwm_tick_i));

   p_hold_no_tick_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !pwm_tick_i |=> $stable(sample_o));

   p_phase_still_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !pwm_tick_i |=> $stable(phase_q));

   p_ans_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pwm_tick_i && answer_i) |=>
         ((PHASE_W'(phase_q - $past(phase_q)) == A_S) ||
          (PHASE_W'(phase_q - $past(phase_q)) == A_M)));

   p_org_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pwm_tick_i && !answer_i) |=>
         ((PHASE_W'(phase_q - $past(phase_q)) == O_S) ||
          (PHASE_W'(phase_q - $past(phase_q)) == O_M)));

   p_sample_nonzero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sample_o != '0);

   p_seq_range_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      int'(seq_idx_w) < SEQ_LEN);

endmodule

bind fsk_tone_gen fsk_tone_gen_chk #(
   .PHASE_W   (PHASE_W),
   .SAMPLE_W  (SAMPLE_W),
   .SEQ_IW    (SEQ_IW),
   .SEQ_LEN   (SEQ_LEN),
   .ANS_SPACE (ANS_SPACE),
   .ANS_MARK  (ANS_MARK),
   .ORG_SPACE (ORG_SPACE),
   .ORG_MARK  (ORG_MARK)
) chk_i (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .pwm_tick_i  (pwm_tick_i),
   .answer_i    (answer_i),
   .sample_o    (sample_o),
   .baud_tick_o (baud_tick_o),
   .phase_q     (phase_q),
   .seq_idx_w   (seq_idx_w)
);

// File: tb/fsk_tone_gen_tb.sv
`timescale 1ns/1ps
module fsk_tone_gen_tb_top;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       tick;
   logic       tx_bit;
   logic       answer;
   logic       psel;
   logic [7:0] sample;
   logic       btick;

   int checks   = 0;
   int failures = 0;
   bit done     = 1'b0;

   always #10 clk = ~clk;

   fsk_tone_gen dut_i (
      .clk_i         (clk),
      .rst_ni        (rst_n),
      .pwm_tick_i    (tick),
      .tx_bit_i      (tx_bit),
      .answer_i      (answer),
      .pattern_sel_i (psel),
      .sample_o      (sample),
      .baud_tick_o   (btick)
   );

   // Reference model state
   int unsigned m_phase;
   int unsigned m_baud;
   int          m_idx;
   bit          m_bit;
   bit [63:0]   seen;
   int          pulses;
   int unsigned lfsr = 32'h1234_5678;
   int          last_sample;

   localparam bit SEQ [12] = '{1,0,1,1,0,0,1,1,1,0,0,0};

   function automatic int ref_sine(input int k);
      real v;
      v = 128.0 + 127.0 * $sin(2.0 * 3.14159265358979 * k / 64.0);
      return $rtoi(v + 0.5);
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic run_ticks(input int n, input bit ans, input bit sel, input string req);
      for (int i = 0; i < n; i++) begin
         int unsigned old;
         int unsigned step;
         int unsigned bnew;
         bit d;
         bit wrap;
         int exp_s;
         @(negedge clk);
         // idle cycle just ended: sample held, pulse gone
         check(sample == last_sample, "R4 hold", sample, last_sample);
         check(btick == 1'b0, "R5 width", btick, 0);
         lfsr = lfsr ^ (lfsr << 13);
         lfsr = lfsr ^ (lfsr >> 17);
         lfsr = lfsr ^ (lfsr << 5);
         tx_bit = lfsr[0];
         answer = ans;
         psel   = sel;
         tick   = 1'b1;
         old  = m_phase;
         d    = sel ? m_bit : tx_bit;
         if (ans) step = d ? 4648 : 4230;
         else     step = d ? 2653 : 2235;
         exp_s = ref_sine(int'(old >> 10));
         seen[old >> 10] = 1'b1;
         m_phase = (old + step) & 32'hFFFF;
         bnew = (m_baud + 627) & 32'hFFFF;
         wrap = (bnew < 627);
         m_baud = bnew;
         if (wrap) begin
            m_bit = SEQ[m_idx];
            m_idx = (m_idx == 11) ? 0 : m_idx + 1;
         end
         @(negedge clk);
         tick = 1'b0;
         check(sample == exp_s, req, sample, exp_s);
         check(btick == wrap, "R5 pulse", btick, wrap);
         if (btick) pulses++;
         last_sample = sample;
      end
   endtask

   initial begin
      rst_n = 1'b0; tick = 1'b0; tx_bit = 1'b0; answer = 1'b1; psel = 1'b0;
      m_phase = 0; m_baud = 0; m_idx = 0; m_bit = 1'b1; seen = '0; pulses = 0;
      repeat (3) @(negedge clk);
      check(sample == 128, "R1 sample", sample, 128);
      check(btick == 1'b0, "R1 pulse", btick, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(sample == 128, "R1 after release", sample, 128);
      last_sample = 128;

      // R2 table points at exact quarter positions
      check(ref_sine(16) == 255 && ref_sine(48) == 1 && ref_sine(1) == 140,
            "R2 ref table", ref_sine(48), 1);

      // R6 from reset: sequence drives data, tx_bit ignored, mark before first pulse
      run_ticks(1500, 1'b1, 1'b1, "R6 answer sequence");
      check(pulses >= 13, "R6 pulse count", pulses, 14);
      // R7 external data, answer channel (R3 steps)
      run_ticks(400, 1'b1, 1'b0, "R7 answer external R3");
      // R7 external data, originate channel
      run_ticks(400, 1'b0, 1'b0, "R7 originate external R3");
      // R6 sequence on originate channel
      run_ticks(700, 1'b0, 1'b1, "R6 originate sequence");
      check(&seen, "R2 all indices", $countones(seen), 64);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule